// File: doc/BRIEF.md
# Local Interrupt Timer with Absolute Deadline Mode

This block is the timer of one core's local interrupt controller. A control register sets the interrupt vector, a mask bit and a two-bit mode field. Two of the modes count down from a programmed initial count: one-shot and periodic. The third compares an absolute deadline against a free-running timestamp counter, which the block takes as an input.

Software reaches four registers through a simple port. Writes take effect at the clock edge and reads are combinational. An expiry produces a single-cycle interrupt request carrying the vector that is programmed at that moment. In deadline mode, a deadline that is already due fires at once. A deadline that fires clears itself, so it does not fire again. Any write that changes the mode disarms the timer and wipes its counts and its deadline.

Top module: `lapic_deadline_timer`

## Requirements
- R1: After reset, all four registers read zero (mode one-shot, vector 0, unmasked) and `irq_valid` is low.
- R2: Register addresses are 0 control, 1 initial count, 2 current count (read-only) and 3 deadline. The control fields are vector bits 7:0, mask bit 16 and mode bits 18:17, with 00 one-shot, 01 periodic, 10 deadline and 11 reserved. The mode field is decoded by equality.
- R3: In one-shot mode, writing a nonzero initial count N raises the interrupt exactly N cycles after the write edge, and only once. The current count then reads zero.
- R4: In periodic mode, the interrupt repeats every N cycles. Writing an initial count of zero stops the countdown.
- R5: In deadline mode, the initial-count and current-count registers read zero, and writes to the initial count are ignored and start nothing.
- R6: Outside deadline mode, the deadline register reads zero and writes to it are ignored.
- R7: In deadline mode, a deadline above the timestamp is stored and reads back. The interrupt fires at the first edge where the timestamp is at least that value. The register then reads zero and nothing fires again.
- R8: In deadline mode, a nonzero deadline at or below the timestamp stores zero and fires on the write edge, visible in the next cycle.
- R9: In deadline mode, a deadline write of zero disarms the timer and raises no interrupt.
- R10: A control write that changes the mode cancels any pending event and clears the initial count, the current count and the deadline. A control write with the same mode keeps them and updates the vector used by later interrupts.
- R11: When the mask bit is set, no interrupt is raised, but all state updates still happen, including the countdown and the deadline clearing itself.
- R12: In the reserved mode no timer runs, writes to the count registers and the deadline are ignored, and those registers read zero.
- R13: Each interrupt is a one-cycle pulse on `irq_valid`, with `irq_vector` equal to the control vector at expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | TS_W | Write data |
| reg_rdata | output | TS_W | Read data for `reg_addr` |
| tsc | input | TS_W | Free-running timestamp counter |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | VEC_W | Vector of the request |

## Verification
The bench builds the block with its defaults: a 32-bit count, a 64-bit timestamp and an 8-bit vector. With these values, the exact firing cycle of each countdown and each deadline can be predicted from the write edge. The timestamp is driven by the bench, so deadlines can be placed before, at and after the current timestamp. The bench also uses a far-future deadline to show that a zero write disarms it.

// File: rtl/lapic_deadline_timer.sv
module lapic_deadline_timer #(
  parameter int CNT_W = 32,
  parameter int TS_W  = 64,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [TS_W-1:0]  reg_wdata,
  output logic [TS_W-1:0]  reg_rdata,
  input  logic [TS_W-1:0]  tsc,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);
  localparam logic [1:0] M_ONE = 2'b00, M_PER = 2'b01, M_DL = 2'b10;
  localparam logic [1:0] A_CTRL = 2'd0, A_INIT = 2'd1, A_CUR = 2'd2, A_DL = 2'd3;
  localparam int MASK_BIT = 16;
  localparam int MODE_LO  = 17;

  logic [VEC_W-1:0] vec;
  logic             mask;
  logic [1:0]       mode;
  logic [CNT_W-1:0] init_cnt, cur_cnt;
  logic [TS_W-1:0]  dl;

  wire [1:0] new_mode = reg_wdata[MODE_LO+1:MODE_LO];
  wire cnt_mode = (mode == M_ONE) || (mode == M_PER);
  wire dl_mode  = (mode == M_DL);
  wire wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  wire wr_init  = reg_wr && reg_addr == A_INIT && cnt_mode;
  wire wr_dl    = reg_wr && reg_addr == A_DL && dl_mode;
  wire mode_chg = wr_ctrl && new_mode != mode;
  wire cnt_exp  = cnt_mode && cur_cnt == CNT_W'(1);
  wire dl_hit   = dl_mode && dl != '0 && tsc >= dl;
  wire dl_now   = wr_dl && reg_wdata != '0 && reg_wdata <= tsc;
  wire fire     = !mode_chg && ((cnt_exp && !wr_init) || (dl_hit && !wr_dl) || dl_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec <= '0; mask <= 1'b0; mode <= M_ONE;
      init_cnt <= '0; cur_cnt <= '0; dl <= '0;
      irq_valid <= 1'b0; irq_vector <= '0;
    end else begin
      if (wr_ctrl) begin
        vec  <= reg_wdata[VEC_W-1:0];
        mask <= reg_wdata[MASK_BIT];
        mode <= new_mode;
      end
      if (mode_chg)     init_cnt <= '0;
      else if (wr_init) init_cnt <= reg_wdata[CNT_W-1:0];

      if (mode_chg)                     cur_cnt <= '0;
      else if (wr_init)                 cur_cnt <= reg_wdata[CNT_W-1:0];
      else if (cnt_exp)                 cur_cnt <= (mode == M_PER) ? init_cnt : '0;
      else if (cnt_mode && cur_cnt != 0) cur_cnt <= cur_cnt - 1'b1;

      if (mode_chg)    dl <= '0;
      else if (wr_dl)  dl <= (reg_wdata > tsc) ? reg_wdata : '0;
      else if (dl_hit) dl <= '0;

      irq_valid  <= fire && !mask;
      irq_vector <= vec;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[VEC_W-1:0] = vec;
        reg_rdata[MASK_BIT] = mask;
        reg_rdata[MODE_LO+1:MODE_LO] = mode;
      end
      A_INIT:  reg_rdata[CNT_W-1:0] = cnt_mode ? init_cnt : '0;
      A_CUR:   reg_rdata[CNT_W-1:0] = cnt_mode ? cur_cnt : '0;
      default: reg_rdata = dl_mode ? dl : '0;
    endcase
  end

  // R6
  dl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_DL) |-> (dl == '0));
  // R5
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DL) |-> (init_cnt == '0 && cur_cnt == '0));
  // R11
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(mask));
  // R7
  dl_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_mode && $past(dl_mode) && !$past(reg_wr) && $past(dl) != '0 && $past(tsc) >= $past(dl))
      |-> (dl == '0));
  // R3
  oneshot_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ONE && $past(mode) == M_ONE && !$past(reg_wr)) |-> (cur_cnt <= $past(cur_cnt)));
endmodule

// File: tb/lapic_deadline_timer_bench.sv
`timescale 1ns/1ps
module lapic_deadline_timer_bench;
  logic        clk = 0, rst_n = 0, reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [63:0] reg_wdata = 0, reg_rdata, tsc = 0;
  logic        irq_valid;
  logic [7:0]  irq_vector;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [63:0] val;

  lapic_deadline_timer u_lapic_deadline_timer (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tsc(tsc),
    .irq_valid(irq_valid), .irq_vector(irq_vector));

  always #2 clk = ~clk;
  always @(posedge clk) begin tsc <= tsc + 1; cyc <= cyc + 1; end

  always @(posedge clk) if (cyc == 150000 && !done) begin
    fails++; checks++;
    $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic logic [63:0] ctrl(input logic [7:0] v, input logic m, input logic [1:0] md);
    logic [63:0] d = '0;
    d[7:0] = v; d[16] = m; d[18:17] = md;
    return d;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic wr_rel(input longint off, output logic [63:0] d);
    @(negedge clk); d = tsc + 64'(off); reg_wr = 1; reg_addr = 2'd3; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk); reg_addr = a; #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic watch(input int span, input int first, input int count, input logic [7:0] v, input string tag);
    int f = -1, n = 0; bit vok = 1;
    for (int i = 0; i < span; i++) begin
      @(negedge clk);
      if (irq_valid) begin
        if (f < 0) f = i;
        n++;
        if (irq_vector != v) vok = 0;
      end
    end
    check(f == first, {tag, " first irq cycle"}, 64'(f), 64'(first));
    check(n == count, {tag, " irq count"}, 64'(n), 64'(count));
    if (count > 0) check(vok, {tag, " R13 vector"}, 64'(vok), 64'd1);
  endtask

  task automatic t_reset;
    check(irq_valid == 0, "R1 irq", 64'(irq_valid), 0);
    for (int a = 0; a < 4; a++) rd_chk(2'(a), 0, "R1 reg");
  endtask

  task automatic t_oneshot;
    wr(0, ctrl(8'h31, 0, 2'b00));
    rd_chk(0, ctrl(8'h31, 0, 2'b00), "R2 ctrl readback");
    wr(1, 5);
    watch(25, 5, 1, 8'h31, "R3");
    rd_chk(2, 0, "R3 cur after");
  endtask

  task automatic t_periodic;
    wr(0, ctrl(8'h42, 0, 2'b01));
    wr(1, 4);
    watch(13, 4, 3, 8'h42, "R4 periodic");
    wr(1, 0);
    watch(20, -1, 0, 8'h42, "R4 stop");
    rd_chk(2, 0, "R4 cur stopped");
  endtask

  task automatic t_same_mode;
    wr(1, 30);
    wr(0, ctrl(8'h55, 0, 2'b01));
    watch(35, 29, 1, 8'h55, "R10 same mode keeps count");
    rd_chk(1, 30, "R10 init kept");
    wr(0, ctrl(8'h55, 0, 2'b00));
    rd_chk(1, 0, "R10 init cleared");
    rd_chk(2, 0, "R10 cur cleared");
    watch(40, -1, 0, 8'h55, "R10 cancelled");
  endtask

  task automatic t_deadline;
    wr(0, ctrl(8'h66, 0, 2'b10));
    wr_rel(1000, val);
    rd_chk(3, val, "R7 stored");
    wr(3, 0);
    rd_chk(3, 0, "R9 cleared");
    watch(1100, -1, 0, 8'h66, "R9 disarm");
    wr_rel(10, val);
    watch(30, 10, 1, 8'h66, "R7 fire");
    rd_chk(3, 0, "R7 self clear");
    wr_rel(0, val);
    watch(10, 0, 1, 8'h66, "R8 equal");
    rd_chk(3, 0, "R8 stores zero");
    wr_rel(-5, val);
    watch(10, 0, 1, 8'h66, "R8 past");
  endtask

  task automatic t_dl_counts;
    wr(1, 7);
    rd_chk(1, 0, "R5 init reads zero");
    rd_chk(2, 0, "R5 cur reads zero");
    watch(20, -1, 0, 8'h66, "R5 no countdown");
    wr_rel(50, val);
    wr(0, ctrl(8'h66, 0, 2'b00));
    wr(0, ctrl(8'h66, 0, 2'b10));
    rd_chk(3, 0, "R10 deadline cleared");
    watch(80, -1, 0, 8'h66, "R10 deadline cancelled");
  endtask

  task automatic t_dl_ignored;
    wr(0, ctrl(8'h11, 0, 2'b00));
    wr_rel(5, val);
    rd_chk(3, 0, "R6 deadline reads zero");
    watch(30, -1, 0, 8'h11, "R6 ignored");
  endtask

  task automatic t_mask;
    wr(0, ctrl(8'h77, 1, 2'b10));
    wr_rel(8, val);
    watch(20, -1, 0, 8'h77, "R11 masked deadline");
    rd_chk(3, 0, "R11 deadline cleared while masked");
    wr(0, ctrl(8'h77, 1, 2'b00));
    wr(1, 3);
    watch(10, -1, 0, 8'h77, "R11 masked countdown");
    rd_chk(2, 0, "R11 count ran while masked");
  endtask

  task automatic t_reserved;
    wr(0, ctrl(8'h12, 0, 2'b11));
    wr(1, 5);
    rd_chk(1, 0, "R12 init zero");
    rd_chk(2, 0, "R12 cur zero");
    wr_rel(3, val);
    rd_chk(3, 0, "R12 deadline zero");
    watch(20, -1, 0, 8'h12, "R12 silent");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_oneshot;
    t_periodic;
    t_same_mode;
    t_deadline;
    t_dl_counts;
    t_dl_ignored;
    t_mask;
    t_reserved;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule